// File: doc/BRIEF.md
# ASCII Hex Command Bus Bridge

This block sits between a byte-level serial receiver and transmitter and a parallel register bus. It reads typed text lines and turns each one into a single bus cycle. A write line has the form `w <addr> <data>` followed by a carriage return. A read line has the form `r <addr>` followed by a carriage return. Address and data are written as hexadecimal digits. When the terminating carriage return arrives, the block raises a one-cycle write or read strobe.

For a read, the block takes the byte returned by the register bus one clock after the strobe. It sends that byte back as two lowercase hex characters and a carriage return, one byte at a time, using a valid/ready handshake toward the transmitter. While a read is in flight, input bytes are dropped and a busy output is raised. This lets the receiving side hold off or discard bytes. The surrounding system runs the serial link at 115200 baud, 8N1, and the block itself works at the byte level.

Top module: `hexcmd_bridge`

## Requirements
- R1: The byte sequence 0x77, 0x20, one or more hex digits, 0x20, one or more hex digits, 0x0D produces `bus_wr` high for exactly one clock, in the cycle after the 0x0D is taken. `bus_addr` and `bus_wdata` carry the parsed values in that cycle, and `bus_rd` stays low.
- R2: The byte sequence 0x72, 0x20, one or more hex digits, 0x0D produces `bus_rd` high for exactly one clock, in the cycle after the 0x0D is taken, with `bus_addr` carrying the parsed address.
- R3: The hex digits 0-9 (0x30-0x39), a-f (0x61-0x66) and A-F (0x41-0x46) are all accepted with their usual values.
- R4: Each digit shifts its field left by four bits and inserts the digit in the low nibble. The address keeps only its low 16 bits and the data keeps only its low 8 bits, so a short field is zero-extended.
- R5: A byte that breaks the grammar aborts the command, and the parser goes back to idle. Idle discards every byte except 0x77 and 0x72.
- R6: A 0x0D that arrives before every required field holds at least one digit ends the command without any strobe.
- R7: The byte on `bus_rdata` is sampled one clock after the `bus_rd` cycle. It is then returned on `tx_data` as the ASCII hex of its high nibble, then of its low nibble (0-9 as 0x30-0x39, 10-15 as 0x61-0x66), then 0x0D. Each reply byte is held with `tx_valid` until a clock edge where `tx_ready` is high.
- R8: `busy` is high from the `bus_rd` cycle until the clock edge that takes the final reply byte. A byte offered on `rx_valid` while `busy` is high is dropped and has no effect on the parse.
- R9: After reset, `bus_wr`, `bus_rd`, `busy` and `tx_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present this cycle |
| busy | output | 1 | Read reply pending; input bytes are dropped |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 8 | Register bus write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Register bus read data, valid the cycle after `bus_rd` |
| tx_data | output | 8 | Reply byte to the transmitter |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Transmitter takes the reply byte at this edge |

## Verification
The bench aims at fields that are too long, where a design that failed to truncate would put wrong upper bits on the bus. It also covers mixed-case digits, which a lowercase-only decoder would treat as an abort. Commands cut short by a stray character or an early carriage return would produce phantom strobes in a design with a loose grammar. Bytes sent during a stalled reply would corrupt the next command if the busy gating leaked. A transmitter that toggles ready at random exposes any reply byte that changes before it is taken, and any design that samples the read data in the wrong cycle.

// File: rtl/hexcmd_pkg.sv
package hexcmd_pkg;

  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_WRITE = 8'h77;
  localparam logic [7:0] CH_READ  = 8'h72;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_GAP,
    PS_ADDR,
    PS_DATA
  } parse_state_t;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_WAIT,
    RS_SEND
  } reply_state_t;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) ||
           (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_val(input logic [7:0] c);
    logic [7:0] t;
    if (c <= 8'h39) t = c - 8'h30;
    else if (c <= 8'h46) t = c - 8'h37;
    else t = c - 8'h57;
    return t[3:0];
  endfunction

  function automatic logic [7:0] nib_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return 8'h57 + {4'h0, n};
  endfunction

endpackage

// File: rtl/hexcmd_parser.sv
module hexcmd_parser
  import hexcmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [7:0]        byte_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              wr_fire,
  output logic              rd_fire
);

  parse_state_t st;
  logic         is_wr;
  logic         got_digit;
  logic         dig;
  logic [3:0]   val;

  assign dig = is_hex(byte_in);
  assign val = hex_val(byte_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PS_IDLE;
      is_wr     <= 1'b0;
      got_digit <= 1'b0;
      addr      <= '0;
      wdata     <= '0;
      wr_fire   <= 1'b0;
      rd_fire   <= 1'b0;
    end else begin
      wr_fire <= 1'b0;
      rd_fire <= 1'b0;
      if (take) begin
        unique case (st)
          PS_IDLE: begin
            if (byte_in == CH_WRITE) begin
              st    <= PS_GAP;
              is_wr <= 1'b1;
            end else if (byte_in == CH_READ) begin
              st    <= PS_GAP;
              is_wr <= 1'b0;
            end
          end
          PS_GAP: begin
            if (byte_in == CH_SPACE) begin
              st        <= PS_ADDR;
              addr      <= '0;
              got_digit <= 1'b0;
            end else begin
              st <= PS_IDLE;
            end
          end
          PS_ADDR: begin
            if (dig) begin
              addr      <= {addr[ADDR_W-5:0], val};
              got_digit <= 1'b1;
            end else if (byte_in == CH_SPACE && is_wr && got_digit) begin
              st        <= PS_DATA;
              wdata     <= '0;
              got_digit <= 1'b0;
            end else begin
              if (byte_in == CH_CR && !is_wr && got_digit) rd_fire <= 1'b1;
              st <= PS_IDLE;
            end
          end
          PS_DATA: begin
            if (dig) begin
              wdata     <= {wdata[DATA_W-5:0], val};
              got_digit <= 1'b1;
            end else begin
              if (byte_in == CH_CR && got_digit) wr_fire <= 1'b1;
              st <= PS_IDLE;
            end
          end
          default: st <= PS_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/hexcmd_reply.sv
module hexcmd_reply
  import hexcmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              active
);

  localparam int NIB = DATA_W / 4;
  localparam int IW  = $clog2(NIB + 1);

  reply_state_t      st;
  logic [DATA_W-1:0] cap;
  logic [IW-1:0]     idx;
  logic [3:0]        nib;

  always_comb begin
    nib = 4'h0;
    for (int k = 0; k < NIB; k++) begin
      if (idx == IW'(k)) nib = cap[(NIB-1-k)*4 +: 4];
    end
  end

  assign tx_data  = (idx == IW'(NIB)) ? CH_CR : nib_ascii(nib);
  assign tx_valid = (st == RS_SEND);
  assign active   = (st != RS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RS_IDLE;
      cap <= '0;
      idx <= '0;
    end else begin
      unique case (st)
        RS_IDLE: if (start) st <= RS_WAIT;
        RS_WAIT: begin
          cap <= rdata;
          idx <= '0;
          st  <= RS_SEND;
        end
        RS_SEND: begin
          if (tx_ready) begin
            if (idx == IW'(NIB)) st <= RS_IDLE;
            else idx <= idx + 1'b1;
          end
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hexcmd_bridge.sv
module hexcmd_bridge
  import hexcmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);

  logic byte_take;
  logic reply_active;
  logic wr_fire;
  logic rd_fire;

  assign busy      = rd_fire | reply_active;
  assign byte_take = rx_valid & ~busy;
  assign bus_wr    = wr_fire;
  assign bus_rd    = rd_fire;

  hexcmd_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
    .clk     (clk),
    .rst     (rst),
    .take    (byte_take),
    .byte_in (rx_data),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire)
  );

  hexcmd_reply #(.DATA_W(DATA_W)) u_reply (
    .clk      (clk),
    .rst      (rst),
    .start    (rd_fire),
    .rdata    (bus_rdata),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .active   (reply_active)
  );

endmodule

// File: rtl/hexcmd_bridge_chk.sv
module hexcmd_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       byte_take,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready
);

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_wr);                                         // R1

  AST_NO_WR_RD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));                                        // R1

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd);                                         // R2

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7

  AST_TX_CHARSET: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ((tx_data >= 8'h30 && tx_data <= 8'h39) ||
                  (tx_data >= 8'h61 && tx_data <= 8'h66) ||
                  tx_data == 8'h0D));                            // R7

  AST_RD_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> busy);                                            // R8

  AST_TAKE_NO_REPLY: assert property (@(posedge clk) disable iff (rst)
    byte_take |-> !tx_valid);                                    // R8

  AST_TX_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);                                          // R8

endmodule

bind hexcmd_bridge hexcmd_bridge_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .byte_take (byte_take),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready)
);

// File: tb/hexcmd_bridge_bench.sv
`timescale 1ns/1ps
module hexcmd_bridge_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        busy;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_rdata = 8'h00;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hexcmd_bridge u_hexcmd_bridge (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // register file of the bench (256 bytes, low address byte)
  logic [7:0] regs [256];
  int nwr = 0, nrd = 0;
  logic [15:0] last_wr_addr = 16'h0, last_rd_addr = 16'h0;
  logic [7:0] got_q[$];
  initial for (int i = 0; i < 256; i++) regs[i] = 8'h00;

  always @(posedge clk) begin
    if (!rst) begin
      if (bus_wr) begin
        regs[bus_addr[7:0]] <= bus_wdata;
        nwr++;
        last_wr_addr <= bus_addr;
      end
      if (bus_rd) begin
        bus_rdata <= regs[bus_addr[7:0]];
        nrd++;
        last_rd_addr <= bus_addr;
      end
      if (tx_valid && tx_ready) got_q.push_back(tx_data);
    end
  end

  // transmitter readiness: pseudo-random unless held off
  bit hold_tx = 0;
  logic [7:0] lf = 8'hA5;
  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    tx_ready <= hold_tx ? 1'b0 : lf[0];
  end

  // behavioural reference model
  int m_phase;
  bit m_isw;
  int m_cnt;
  int m_a, m_d;
  bit e_wr, e_rd, e_wait;
  int e_addr, e_data;
  logic [7:0] e_txq[$];

  function automatic int digit_of(input logic [7:0] c);
    if (c inside {[8'h30:8'h39]}) return int'(c) - 48;
    if (c inside {[8'h61:8'h66]}) return int'(c) - 87;
    if (c inside {[8'h41:8'h46]}) return int'(c) - 55;
    return -1;
  endfunction

  function automatic bit e_busy();
    return e_rd || e_wait || (e_txq.size() > 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_isw = 0; m_cnt = 0; m_a = 0; m_d = 0;
      e_wr = 0; e_rd = 0; e_wait = 0;
      e_txq.delete();
    end else begin
      bit acc;
      int dv;
      string s;
      acc = rx_valid && !e_busy();
      if (e_txq.size() > 0 && tx_ready) void'(e_txq.pop_front());
      if (e_wait) begin
        s = $sformatf("%02h", bus_rdata);
        e_txq.push_back(s[0]);
        e_txq.push_back(s[1]);
        e_txq.push_back(8'h0D);
        e_wait = 0;
      end
      if (e_rd) e_wait = 1;
      e_rd = 0;
      e_wr = 0;
      if (acc) begin
        dv = digit_of(rx_data);
        if (m_phase == 0) begin
          if (rx_data == "w") begin m_phase = 1; m_isw = 1; end
          else if (rx_data == "r") begin m_phase = 1; m_isw = 0; end
        end else if (m_phase == 1) begin
          if (rx_data == " ") begin m_phase = 2; m_cnt = 0; m_a = 0; end
          else m_phase = 0;
        end else if (m_phase == 2) begin
          if (dv >= 0) begin m_a = (m_a * 16 + dv) % 65536; m_cnt++; end
          else if (rx_data == " " && m_isw && m_cnt > 0) begin m_phase = 3; m_cnt = 0; m_d = 0; end
          else begin
            if (rx_data == 8'h0D && !m_isw && m_cnt > 0) begin e_rd = 1; e_addr = m_a; end
            m_phase = 0;
          end
        end else begin
          if (dv >= 0) begin m_d = (m_d * 16 + dv) % 256; m_cnt++; end
          else begin
            if (rx_data == 8'h0D && m_cnt > 0) begin e_wr = 1; e_addr = m_a; e_data = m_d; end
            m_phase = 0;
          end
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(bus_wr == e_wr, "R1", "bus_wr", bus_wr, e_wr);
      check(bus_rd == e_rd, "R2", "bus_rd", bus_rd, e_rd);
      check(busy == e_busy(), "R8", "busy", busy, e_busy());
      check(tx_valid == (e_txq.size() > 0), "R7", "tx_valid", tx_valid, e_txq.size() > 0);
      if (tx_valid && e_txq.size() > 0)
        check(tx_data == e_txq[0], "R7", "tx_data", tx_data, e_txq[0]);
      if (e_wr || e_rd)
        check(bus_addr == 16'(e_addr), "R4", "bus_addr", bus_addr, e_addr);
      if (e_wr)
        check(bus_wdata == 8'(e_data), "R4", "bus_wdata", bus_wdata, e_data);
    end
  end

  // stimulus helpers
  task automatic put_byte(input logic [7:0] b, input bit wait_idle);
    @(negedge clk);
    if (wait_idle) while (busy) @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_line(input string s, input bit wait_idle = 1);
    for (int i = 0; i < s.len(); i++) put_byte(s[i], wait_idle);
    put_byte(8'h0D, wait_idle);
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_reply(input string s, input string req);
    string g;
    g = "";
    foreach (got_q[i]) g = {g, string'(got_q[i])};
    total++;
    if (g != {s, "\r"}) begin
      bad++;
      $display("FAIL %s reply actual=\"%s\" expected=\"%s\\r\"", req, g, s);
    end
    got_q.delete();
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!bus_wr && !bus_rd, "R9", "strobes after reset", {bus_wr, bus_rd}, 0);
    check(!busy && !tx_valid, "R9", "busy/tx_valid after reset", {busy, tx_valid}, 0);

    // R1 plain write, R2/R7 read it back
    send_line("w 4cd9 1a"); settle();
    check(regs[8'hd9] == 8'h1a, "R1", "write landed", regs[8'hd9], 8'h1a);
    check(last_wr_addr == 16'h4cd9, "R1", "write address", last_wr_addr, 16'h4cd9);
    r0 = nrd;
    send_line("r d9"); settle();
    check(nrd == r0 + 1, "R2", "read strobe count", nrd, r0 + 1);
    expect_reply("1a", "R7");

    // R3 mixed case
    send_line("w 3B Cd"); settle();
    check(regs[8'h3b] == 8'hcd, "R3", "mixed-case write", regs[8'h3b], 8'hcd);
    send_line("r 3b"); settle();
    expect_reply("cd", "R3");

    // R4 truncation and zero extension
    send_line("w 12345 1ff"); settle();
    check(last_wr_addr == 16'h2345, "R4", "long address kept low 16", last_wr_addr, 16'h2345);
    check(regs[8'h45] == 8'hff, "R4", "long data kept low 8", regs[8'h45], 8'hff);
    send_line("r 7"); settle();
    check(last_rd_addr == 16'h0007, "R4", "short address", last_rd_addr, 16'h0007);
    expect_reply("00", "R4");

    // R5 aborts
    w0 = nwr; r0 = nrd;
    send_line("w 1x 2"); settle();
    send_line("r 1 2"); settle();
    send_line("ww 5 6"); settle();
    send_line("w5 6"); settle();
    check(nwr == w0, "R5", "no write after abort", nwr, w0);
    check(nrd == r0, "R5", "no read after abort", nrd, r0);
    send_line("zq r 45"); settle();
    check(nrd == r0 + 1, "R5", "recovery after junk", nrd, r0 + 1);
    expect_reply("ff", "R5");

    // R6 early carriage return
    w0 = nwr; r0 = nrd;
    send_line("w "); settle();
    send_line("w 5"); settle();
    send_line("w 5 "); settle();
    send_line("r "); settle();
    check(nwr == w0, "R6", "no write on short line", nwr, w0);
    check(nrd == r0, "R6", "no read on short line", nrd, r0);

    // R8 bytes dropped while a reply is stalled
    hold_tx = 1;
    send_line("r 3b");
    send_line("w 7 55", 0);
    repeat (5) @(negedge clk);
    check(busy == 1'b1, "R8", "busy while stalled", busy, 1);
    hold_tx = 0;
    settle();
    expect_reply("cd", "R8");
    check(regs[8'h07] == 8'h00, "R8", "write during busy dropped", regs[8'h07], 0);
    send_line("r 07"); settle();
    expect_reply("00", "R8");

    // back-to-back reads with random ready
    send_line("w a0 9E"); settle();
    send_line("r A0");
    send_line("r d9"); settle();
    expect_reply("9e\r1a", "R7");

    repeat (5) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule